// File: doc/BRIEF.md
# Carrier Presence Detector with Noise Filter

This block sits behind the receive comparator of an on-off keyed coax modem. Its input is a one-bit sliced copy of the line signal, sampled on a fast system clock. While the carrier is present, the slice toggles at the carrier rate. While the carrier is absent, the slice sits at a constant level. The block turns this into a baseband receive bit: high when the line is quiet, low while a qualified carrier is present.

Line noise produces short bursts of toggling, and these must not reach the data output. A burst is accepted only after the carrier has been continuously present for a noise-filter time. That time depends on the selected signalling rate. The release side is delayed by a matching amount, so the width of the output low pulse follows the width of the keyed burst, and the duty cycle survives the filter.

While the local node is transmitting, the direction controller raises a transmit flag, and the receive output is then forced high. Reception keeps working in the low-power standby rate setting. A one-cycle pulse marks every rising edge of the receive output; the direction controller uses it to restart its hold-off timer.

Top module: `carrier_detect`

## Requirements
- R1: After reset, and whenever the line has been quiet, `rx_data_o` is 1 and `rx_rise_o` is 0.
- R2: The slice passes through two synchroniser flops. The carrier counts as present while an input transition has been seen within the last WIN = 2·CLK_KHZ/CARRIER_KHZ cycles, which is 32 by default. For a qualifying burst, `rx_data_o` falls exactly LIM+4 clock edges after the first input transition.
- R3: Let SPAN be the number of cycles from the first transition of an isolated burst to its last. The burst drives `rx_data_o` low if and only if SPAN + WIN ≥ LIM. A shorter burst leaves the output high throughout.
- R4: LIM is CLK_KHZ·4000/10^6 cycles (4 µs) when `rate_mode_i` = 2'b00, the slowest rate. For 2'b01 and 2'b10 it is CLK_KHZ·2000/10^6 cycles (2 µs). With the defaults these are 139 and 69.
- R5: A qualified burst holds `rx_data_o` low for exactly SPAN cycles. The output returns high LIM+4 edges after the last input transition.
- R6: While `tx_mode_i` is 1, `rx_data_o` is 1 from the next clock edge on, whatever the slice does.
- R7: `rate_mode_i` = 2'b11 (standby) keeps detection running, using the 2 µs filter time.
- R8: `rx_rise_o` is a single-cycle pulse, asserted in the first cycle that `rx_data_o` is high again after being low.
- R9: A 50 % keyed bit at the fastest rate (a burst lasting half of a 302-cycle bit) gives a low pulse between 40 % and 60 % of the bit time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, a multiple of the carrier frequency |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_slice_i | input | 1 | Asynchronous comparator output of the receive path |
| rate_mode_i | input | 2 | Rate setting: 00 slow, 01 medium, 10 fast, 11 standby |
| tx_mode_i | input | 1 | High while the local node owns the line for transmit |
| rx_data_o | output | 1 | Received baseband bit, low while a qualified carrier is present |
| rx_rise_o | output | 1 | One-cycle pulse on each rising edge of rx_data_o |

## Verification
A burst's first transition is taken as reference edge 0. Counting the two synchroniser flops, the edge detector, the presence counter, the qualification counter and the output register, the fall is due at edge LIM+4 and the rise at edge SPAN+LIM+4. The transmit override lands one edge after the flag is raised. The bench drives and samples on the falling clock edge and numbers its loop iterations by the rising edges that have passed, so each comparison is made against an exact iteration index computed from LIM, WIN and SPAN. The sweep covers every rate setting against burst lengths from 1 to 18 transitions, which spans both sides of the SPAN + WIN ≥ LIM boundary in every mode.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  typedef enum logic [1:0] {
    RATE_SLOW  = 2'b00,
    RATE_MID   = 2'b01,
    RATE_FAST  = 2'b10,
    RATE_STBY  = 2'b11
  } rate_mode_e;

  // Only the slowest rate uses the long filter; standby keeps the short one.
  function automatic logic use_long_filter(rate_mode_e m);
    return m == RATE_SLOW;
  endfunction
endpackage

// File: rtl/cpd_sync.sv
module cpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic toggle_o
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      vld_q <= '0;
    end else begin
      sh_q  <= {sh_q[STAGES-1:0], d_i};
      vld_q <= {vld_q[STAGES-1:0], 1'b1};
    end
  end

  // Mask the edge detector until every stage holds sampled data.
  assign toggle_o = vld_q[STAGES] & (sh_q[STAGES] ^ sh_q[STAGES-1]);
endmodule

// File: rtl/cpd_presence.sv
module cpd_presence #(
  parameter int WIN = 32,
  localparam int WW = $clog2(WIN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic toggle_i,
  output logic present_o
);
  localparam logic [WW-1:0] WinMax = WIN[WW-1:0];

  logic [WW-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= WinMax;
    else if (toggle_i)        age_q <= '0;
    else if (age_q != WinMax) age_q <= age_q + 1'b1;
  end

  assign present_o = age_q != WinMax;

  // R2
  edge_sets_present_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_i |=> present_o);
endmodule

// File: rtl/cpd_qualify.sv
module cpd_qualify #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          present_i,
  input  logic [CW-1:0] lim_i,
  input  logic [CW-1:0] hold_i,
  output logic          qual_o
);
  logic          qual_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qual_q <= 1'b0;
      run_q  <= '0;
    end else if (!qual_q) begin
      if (!present_i) begin
        run_q <= '0;
      end else if (run_q >= lim_i - 1'b1) begin
        qual_q <= 1'b1;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      // Hold-off after carrier loss matches the qualify delay.
      if (present_i) begin
        run_q <= '0;
      end else if (run_q >= hold_i - 1'b1) begin
        qual_q <= 1'b0;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign qual_o = qual_q;

  // R3
  qual_needs_carrier_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(qual_o) |-> $past(present_i));
  // R5
  release_needs_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(qual_o) |-> !$past(present_i));
endmodule

// File: rtl/carrier_detect.sv
module carrier_detect #(
  parameter int CLK_KHZ     = 34816,
  parameter int CARRIER_KHZ = 2176,
  parameter int LONG_NS     = 4000,
  parameter int SHORT_NS    = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_slice_i,
  input  logic [1:0] rate_mode_i,
  input  logic       tx_mode_i,
  output logic       rx_data_o,
  output logic       rx_rise_o
);
  import cpd_pkg::*;

  localparam int LimLong  = CLK_KHZ * LONG_NS / 1000000;
  localparam int LimShort = CLK_KHZ * SHORT_NS / 1000000;
  localparam int Win      = 2 * CLK_KHZ / CARRIER_KHZ;
  localparam int CW       = $clog2(LimLong + 1);

  // LimShort must exceed Win so the hold-off stays positive.
  rate_mode_e    mode;
  logic [CW-1:0] lim;
  logic [CW-1:0] hold;
  logic          toggle;
  logic          present;
  logic          qual;
  logic          rx_next;
  logic          rx_q;
  logic          rise_q;

  assign mode = rate_mode_e'(rate_mode_i);

  always_comb begin
    lim  = use_long_filter(mode) ? LimLong[CW-1:0] : LimShort[CW-1:0];
    hold = lim - Win[CW-1:0];
  end

  cpd_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      (rx_slice_i),
    .toggle_o (toggle)
  );

  cpd_presence #(.WIN(Win)) i_presence (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .toggle_i  (toggle),
    .present_o (present)
  );

  cpd_qualify #(.CW(CW)) i_qualify (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .present_i (present),
    .lim_i     (lim),
    .hold_i    (hold),
    .qual_o    (qual)
  );

  assign rx_next = !(qual && !tx_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q   <= 1'b1;
      rise_q <= 1'b0;
    end else begin
      rx_q   <= rx_next;
      rise_q <= rx_next & ~rx_q;
    end
  end

  assign rx_data_o = rx_q;
  assign rx_rise_o = rise_q;

  // R6
  tx_forces_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_mode_i |=> rx_data_o);
  // R1
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qual |=> rx_data_o);
  // R8
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rise_o |=> !rx_rise_o);
  // R8
  rise_on_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rise_o |-> (rx_data_o && !$past(rx_data_o)));
endmodule

// File: tb/test_carrier_detect.sv
module test_carrier_detect;
  localparam int ClkPeriod = 10;
  localparam int ClkKhz    = 34816;
  localparam int Win       = 2 * ClkKhz / 2176;
  localparam int LimLong   = ClkKhz * 4000 / 1000000;
  localparam int LimShort  = ClkKhz * 2000 / 1000000;
  localparam int Half      = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_slice = 1'b0;
  logic [1:0] rate_mode = 2'b00;
  logic       tx_mode = 1'b0;
  logic       rx_data;
  logic       rx_rise;

  int n_chk = 0;
  int n_fail = 0;

  always #(ClkPeriod / 2) clk = ~clk;

  carrier_detect i_carrier_detect (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rx_slice_i  (rx_slice),
    .rate_mode_i (rate_mode),
    .tx_mode_i   (tx_mode),
    .rx_data_o   (rx_data),
    .rx_rise_o   (rx_rise)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tx_at: -1 none, -2 held high for the whole burst, else iteration to raise it.
  task automatic burst(input int n, input int lim, input int tx_at, output int low_w);
    int span = (n - 1) * Half;
    int total = span + lim + Win + 30;
    int first_low = -1;
    int low_cnt = 0;
    int rise_cnt = 0;
    int rise_at = -1;
    bit qual = (span + Win) >= lim;
    if (tx_at == -2) tx_mode = 1'b1;
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      if (!rx_data) begin
        if (first_low < 0) first_low = k;
        low_cnt++;
      end
      if (rx_rise) begin
        rise_cnt++;
        rise_at = k;
      end
      if (k == tx_at) tx_mode = 1'b1;
      if ((k % Half == 0) && (k / Half < n)) rx_slice = ~rx_slice;
    end
    tx_mode = 1'b0;
    low_w = low_cnt;
    if (tx_at == -2) begin
      chk(low_cnt == 0, "R6 held low cycles", low_cnt, 0);
      chk(rise_cnt == 0, "R6 rise pulses", rise_cnt, 0);
    end else if (tx_at >= 0) begin
      chk(low_cnt == tx_at - (lim + 4) + 1, "R6 low cycles before override", low_cnt,
          tx_at - (lim + 4) + 1);
      chk(rise_at == tx_at + 1, "R6 override edge", rise_at, tx_at + 1);
    end else if (qual) begin
      chk(first_low == lim + 4, "R2 fall latency", first_low, lim + 4);
      chk(low_cnt == span, "R5 low width", low_cnt, span);
      chk(rise_cnt == 1, "R8 rise count", rise_cnt, 1);
      chk(rise_at == span + lim + 4, "R8 rise position", rise_at, span + lim + 4);
    end else begin
      chk(low_cnt == 0, "R3 short burst low cycles", low_cnt, 0);
      chk(rise_cnt == 0, "R3 short burst rise pulses", rise_cnt, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    // R1 reset state
    chk(rx_data == 1'b1, "R1 rx_data after reset", int'(rx_data), 1);
    chk(rx_rise == 1'b0, "R1 rx_rise after reset", int'(rx_rise), 0);

    // R4 / R7: sweep every rate setting against burst length
    for (int m = 0; m < 4; m++) begin
      rate_mode = m[1:0];
      for (int n = 1; n <= 18; n++) begin
        burst(n, (m == 0) ? LimLong : LimShort, -1, w);
      end
      repeat (5) @(negedge clk);
      chk(rx_data == 1'b1, (m == 3) ? "R7 idle after standby sweep" : "R4 idle after sweep",
          int'(rx_data), 1);
    end

    // R6 held transmit flag, fast rate
    rate_mode = 2'b10;
    burst(18, LimShort, -2, w);
    // R6 override raised in the middle of a qualified burst
    burst(18, LimShort, 100, w);
    repeat (5) @(negedge clk);
    chk(rx_data == 1'b1, "R1 idle after override", int'(rx_data), 1);

    // R9 50% keyed bit at the fast rate, bit time 302 cycles
    burst(19, LimShort, -1, w);
    chk((w * 100 >= 40 * 302) && (w * 100 <= 60 * 302), "R9 duty low cycles", w, 151);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule